// File: doc/BRIEF.md
# Serial ADC Frame Master

This block is the host-side master for a serial 12-bit converter run with the converter's clock taken from the serial interface. When it accepts a start request with a channel number, an input-range choice and an input-mode choice, it builds an 8-bit command, pulls chip select low and runs exactly one frame of 24 serial clocks. The serial clock comes from the system clock through a programmable half-period divider.

The first 8 clocks send the command. The converter then raises its strobe line for one clock. The next 12 clocks carry the conversion result, most significant bit first, and the remaining clocks carry zero fill. At the end of the frame the block releases chip select and presents the 12-bit result with a one-cycle done pulse. It keeps two sticky error flags: one for a strobe that never appeared, one for a divider setting above the allowed maximum.

Top module: `adc_frame_ctrl`

## Requirements
- R1: A frame has exactly 24 rising and 24 falling edges on `sclk`. `sclk` is low whenever `cs_n` is high.
- R2: The command goes out MSB first as {1'b1, `chan[2:0]`, `unipolar`, `single_ended`, 2'b11}. The value on `mosi` at rising edge k (k = 1..8) is command bit 8-k. After the 8th falling edge `mosi` stays 0 until the frame ends.
- R3: `mosi` changes only on the system cycle where `sclk` falls. It never changes while `sclk` is high.
- R4: The result is taken from `miso` on rising edges 10 through 21, MSB first, with bit 11 at edge 10. The converter drives each bit on the falling edge just before the rising edge that samples it.
- R5: Each `sclk` phase lasts `half_m1`+1 system clocks. A start with `half_m1` greater than `MAX_HALF_M1` is refused: no frame runs, and `div_err` is set and stays set until reset.
- R6: `cs_n` falls on the cycle after an accepted start. The first rising edge of `sclk` follows one half-period later. `busy` is high exactly while `cs_n` is low.
- R7: `cs_n` rises one half-period after the 24th falling edge. On that same cycle `done` is high for a single cycle and `result` holds the new value. `result` changes on no other cycle.
- R8: `conv_strobe` is sampled at rising edge 9. If it is low there, `strobe_err` is set and stays set until reset.
- R9: A start request while a frame is running has no effect. The running command is unchanged, and no second frame follows.
- R10: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `done`=0, `result`=0, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, taken when idle |
| chan | input | 3 | Channel select for the command |
| unipolar | input | 1 | Range bit of the command |
| single_ended | input | 1 | Input-mode bit of the command |
| half_m1 | input | DIV_W | Serial clock half-period minus one, in system clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 12 | Last captured conversion result |
| strobe_err | output | 1 | Sticky: strobe missing after command |
| div_err | output | 1 | Sticky: divider setting refused |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Command data to converter |
| miso | input | 1 | Result data from converter |
| conv_strobe | input | 1 | Converter end-of-command strobe |

## Verification
The bench runs a frame for every channel combined with every range and mode choice, under three divider settings. This separates command bit order from result bit order and shows that the edge timing scales with the half-period. The result patterns include all zeros, all ones, a lone MSB and a lone LSB. These expose an off-by-one capture window or a reversed shift direction, and the sweep values add mixed patterns. Separate frames cover a missing strobe, a divider one above the maximum, and a start pulse injected mid-frame. These show that each fault flag is driven by its own condition and that a busy frame cannot be disturbed.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    localparam int CMD_BITS   = 8;
    localparam int RES_BITS   = 12;
    localparam int FRAME_CLKS = 24;
    localparam int LAST_PHASE = 2 * FRAME_CLKS;        // idle-low phase after final fall
    localparam int PH_W       = $clog2(LAST_PHASE + 1);
    localparam int EDGE_W     = $clog2(FRAME_CLKS + 1);
    localparam int STROBE_EDGE    = CMD_BITS + 1;       // rising edge that checks strobe
    localparam int FIRST_RES_EDGE = CMD_BITS + 2;       // rising edge capturing MSB
    localparam int LAST_RES_EDGE  = FIRST_RES_EDGE + RES_BITS - 1;

    localparam logic [1:0] PWR_EXT_CLK = 2'b11;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fsm_t;

    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single_ended;
    } req_t;

    typedef struct packed {
        logic              rise;
        logic              fall;
        logic              last;
        logic [EDGE_W-1:0] edge_no;
    } sclk_ev_t;

    function automatic logic [CMD_BITS-1:0] make_cmd(input req_t r);
        return {1'b1, r.chan, r.unipolar, r.single_ended, PWR_EXT_CLK};
    endfunction

    function automatic logic in_capture(input logic [EDGE_W-1:0] e);
        return (e >= EDGE_W'(FIRST_RES_EDGE)) && (e <= EDGE_W'(LAST_RES_EDGE));
    endfunction

endpackage

// File: rtl/adcf_sclk_gen.sv
module adcf_sclk_gen
    import adcf_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             sclk,
    output sclk_ev_t         ev
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_q;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  phase_nx;
    logic             tick;
    logic             at_end;
    logic [PH_W:0]    edge_calc;

    assign tick      = run && (cnt == half_q);
    assign at_end    = (phase == PH_W'(LAST_PHASE));
    assign phase_nx  = phase + 1'b1;
    assign edge_calc = ({1'b0, phase} + (PH_W+1)'(2)) >> 1;

    always_comb begin
        ev.rise    = tick && !at_end && !phase[0];
        ev.fall    = tick && phase[0];
        ev.last    = tick && at_end;
        ev.edge_no = edge_calc[EDGE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            half_q <= '0;
            phase  <= '0;
            sclk   <= 1'b0;
        end else if (load) begin
            cnt    <= '0;
            half_q <= half_m1;
            phase  <= '0;
            sclk   <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            if (!at_end) begin
                phase <= phase_nx;
                sclk  <= phase_nx[0];
            end
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adcf_shifter.sv
module adcf_shifter
    import adcf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [CMD_BITS-1:0] cmd_in,
    input  logic                rise,
    input  logic                fall,
    input  logic [EDGE_W-1:0]   edge_no,
    input  logic                miso,
    output logic                mosi,
    output logic [RES_BITS-1:0] res
);

    logic [CMD_BITS-1:0] cmd_sr;

    assign mosi = cmd_sr[CMD_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sr <= '0;
        end else if (load) begin
            cmd_sr <= cmd_in;
        end else if (fall) begin
            cmd_sr <= {cmd_sr[CMD_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            res <= '0;
        end else if (rise && in_capture(edge_no)) begin
            res <= {res[RES_BITS-2:0], miso};
        end
    end

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adcf_pkg::*;
#(
    parameter int DIV_W       = 10,
    parameter int MAX_HALF_M1 = 499
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          chan,
    input  logic                unipolar,
    input  logic                single_ended,
    input  logic [DIV_W-1:0]    half_m1,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic                strobe_err,
    output logic                div_err,
    output logic                cs_n,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    input  logic                conv_strobe
);

    localparam logic [DIV_W-1:0] HALF_LIMIT = DIV_W'(MAX_HALF_M1);

    fsm_t                state;
    sclk_ev_t            ev;
    req_t                req;
    logic                div_ok;
    logic                accept;
    logic [RES_BITS-1:0] res_sr;

    assign req    = '{chan: chan, unipolar: unipolar, single_ended: single_ended};
    assign div_ok = (half_m1 <= HALF_LIMIT);
    assign accept = (state == ST_IDLE) && start && div_ok;
    assign busy   = (state == ST_RUN);

    adcf_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .run     (busy),
        .half_m1 (half_m1),
        .sclk    (sclk),
        .ev      (ev)
    );

    adcf_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .cmd_in  (make_cmd(req)),
        .rise    (ev.rise),
        .fall    (ev.fall),
        .edge_no (ev.edge_no),
        .miso    (miso),
        .mosi    (mosi),
        .res     (res_sr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cs_n       <= 1'b1;
            done       <= 1'b0;
            result     <= '0;
            strobe_err <= 1'b0;
            div_err    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (div_ok) begin
                            state <= ST_RUN;
                            cs_n  <= 1'b0;
                        end else begin
                            div_err <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (ev.rise && (ev.edge_no == EDGE_W'(STROBE_EDGE)) && !conv_strobe) begin
                        strobe_err <= 1'b1;
                    end
                    if (ev.last) begin
                        state  <= ST_IDLE;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                        result <= res_sr;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adcf_checker.sv
module adcf_checker
    import adcf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cs_n,
    input logic                sclk,
    input logic                mosi,
    input logic                busy,
    input logic                done,
    input logic [RES_BITS-1:0] result,
    input logic                strobe_err,
    input logic                div_err
);

    logic              sclk_q;
    logic              cs_q;
    logic [EDGE_W-1:0] fall_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            fall_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (cs_n && cs_q) begin
                fall_cnt <= '0;
            end else if (sclk_q && !sclk) begin
                fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    assert_idle_sclk_low_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_frame_edges_R1: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !cs_q) |-> (fall_cnt == EDGE_W'(FRAME_CLKS)));

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    assert_busy_cs_R6: assert property (@(posedge clk) disable iff (rst)
        busy == !cs_n);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_release_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(cs_n));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_strobe_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        strobe_err |=> strobe_err);

    assert_div_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        div_err |=> div_err);

endmodule

bind adc_frame_ctrl adcf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .mosi       (mosi),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .strobe_err (strobe_err),
    .div_err    (div_err)
);

// File: tb/sim_adc_frame_ctrl.sv
module sim_adc_frame_ctrl;

    localparam int DIV_W = 10;
    localparam int MAXH  = 499;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [2:0]       chan = '0;
    logic             unipolar = 1'b0;
    logic             single_ended = 1'b0;
    logic [DIV_W-1:0] half_m1 = '0;
    logic             busy, done, strobe_err, div_err, cs_n, sclk, mosi;
    logic [11:0]      result;
    logic             miso = 1'b0;
    logic             conv_strobe = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2ns clk = ~clk;

    adc_frame_ctrl #(.DIV_W(DIV_W), .MAX_HALF_M1(MAXH)) u0 (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .unipolar(unipolar),
        .single_ended(single_ended), .half_m1(half_m1), .busy(busy), .done(done),
        .result(result), .strobe_err(strobe_err), .div_err(div_err), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso), .conv_strobe(conv_strobe)
    );

    // converter model
    logic [7:0]  dev_cmd = '0;
    logic [11:0] dev_val = '0;
    bit          dev_nostrobe = 1'b0;
    int          dev_rise = 0;
    int          dev_fall = 0;

    always @(negedge cs_n) begin
        dev_rise = 0;
        dev_fall = 0;
        dev_cmd  = '0;
    end

    always @(posedge sclk) begin
        dev_rise = dev_rise + 1;
        if (dev_rise <= 8) dev_cmd = {dev_cmd[6:0], mosi};
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            dev_fall = dev_fall + 1;
            if (dev_fall == 8) conv_strobe <= !dev_nostrobe;
            else if (dev_fall == 9) conv_strobe <= 1'b0;
            if (dev_fall >= 9 && dev_fall <= 20) miso <= dev_val[20 - dev_fall];
            else miso <= 1'b0;
        end
    end

    // port monitor, sampled away from the active edge
    int cyc = 0, n_r = 0, n_f = 0, n_cs_fall = 0, mosi_bad = 0;
    int t_cs0 = 0, t_r1 = 0, t_lf = 0, t_csr = 0, t_done = 0, n_done = 0;
    logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (p_cs && !cs_n) begin
                t_cs0 = cyc; n_r = 0; n_f = 0; mosi_bad = 0;
                n_cs_fall = n_cs_fall + 1;
            end
            if (!p_sclk && sclk) begin
                n_r = n_r + 1;
                if (n_r == 1) t_r1 = cyc;
            end
            if (p_sclk && !sclk) begin
                n_f = n_f + 1;
                t_lf = cyc;
            end
            if (sclk && (mosi !== p_mosi)) mosi_bad = mosi_bad + 1;
            if (n_f >= 8 && !cs_n && mosi !== 1'b0) mosi_bad = mosi_bad + 1;
            if (!p_cs && cs_n) t_csr = cyc;
            if (done) begin
                n_done = n_done + 1;
                t_done = cyc;
            end
        end
        p_sclk = sclk;
        p_cs   = cs_n;
        p_mosi = mosi;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int ch, input int md, input int hm1,
                             input logic [11:0] val, input bit nostb, input int poke);
        int h;
        int w;
        int dn0;
        int cs0;
        logic [7:0] exp_cmd;
        h = hm1 + 1;
        exp_cmd = {1'b1, 3'(ch), md[1], md[0], 2'b11};
        dev_val = val;
        dev_nostrobe = nostb;
        dn0 = n_done;
        @(negedge clk);
        start = 1'b1; chan = 3'(ch); unipolar = md[1]; single_ended = md[0];
        half_m1 = DIV_W'(hm1);
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 4000) begin
            @(negedge clk);
            w = w + 1;
            if (poke != 0 && w == poke) begin
                start = 1'b1; chan = ~3'(ch); unipolar = ~md[1]; half_m1 = '0;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(w < 4000, "R7 done seen", w, 0);
        chk(result == val, "R4 result", int'(result), int'(val));
        @(negedge clk);
        chk(dev_cmd == exp_cmd, "R2 command", int'(dev_cmd), int'(exp_cmd));
        chk(n_r == 24 && n_f == 24, "R1 edge count", n_r * 100 + n_f, 2424);
        chk(mosi_bad == 0, "R3 mosi stable", mosi_bad, 0);
        chk(t_r1 - t_cs0 == h, "R6 lead", t_r1 - t_cs0, h);
        chk(t_lf - t_cs0 == 48 * h, "R5 half period", t_lf - t_cs0, 48 * h);
        chk(t_csr - t_lf == h, "R7 trail", t_csr - t_lf, h);
        chk(t_done == t_csr && n_done == dn0 + 1, "R7 done with release",
            t_done - t_csr, 0);
        if (poke != 0) begin
            cs0 = n_cs_fall;
            repeat (4 * h + 10) @(negedge clk);
            chk(n_cs_fall == cs0 && cs_n && n_done == dn0 + 1, "R9 busy start ignored",
                n_cs_fall - cs0, 0);
        end
    endtask

    initial begin
        #(4ns * 150000);
        failures = failures + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && !sclk && !mosi && !busy && !done, "R10 reset pins", 0, 0);
        chk(result == 12'h000 && !strobe_err && !div_err, "R10 reset state",
            int'(result), 0);

        // edge patterns for the capture window
        run_frame(0, 0, 0, 12'h000, 1'b0, 0);
        run_frame(7, 3, 0, 12'hFFF, 1'b0, 0);
        run_frame(2, 1, 1, 12'h800, 1'b0, 0);
        run_frame(5, 2, 2, 12'h001, 1'b0, 0);

        // sweep over channels, range and mode bits, three dividers
        for (int c = 0; c < 8; c++) begin
            for (int m = 0; m < 4; m++) begin
                v = 12'((c * 523 + m * 1361 + 12'hA5) ^ (m << 9));
                run_frame(c, m, (c + m) % 3, v, 1'b0, 0);
            end
        end
        chk(!strobe_err, "R8 no false strobe error", int'(strobe_err), 0);
        chk(!div_err, "R5 no false divider error", int'(div_err), 0);

        // start during a frame
        run_frame(3, 2, 1, 12'h5A3, 1'b0, 30);

        // divider above the limit is refused
        @(negedge clk);
        start = 1'b1; half_m1 = DIV_W'(MAXH + 1);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(cs_n && !busy, "R5 refused start", int'(cs_n), 1);
        chk(div_err, "R5 divider error set", int'(div_err), 1);

        // missing strobe
        chk(!strobe_err, "R8 clear before fault", int'(strobe_err), 0);
        run_frame(6, 1, 0, 12'h3C6, 1'b1, 0);
        chk(strobe_err, "R8 strobe error set", int'(strobe_err), 1);
        run_frame(1, 0, 0, 12'h7E1, 1'b0, 0);
        chk(strobe_err && div_err, "R8 R5 errors sticky",
            int'({strobe_err, div_err}), 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule